// File: doc/BRIEF.md
# Debounced Pin Edge Interrupt Detector

This block watches a group of general-purpose input pins in a slow clock domain of about 32 kHz and raises one interrupt line when a selected transition appears on any pin. Each pin passes through a two-flop synchronizer, then a filter that waits for a programmable number of stable samples before it accepts a new level. The filtered level then goes to a per-pin transition detector. The detector watches for a rising or a falling transition, chosen per pin. An accepted transition on an unmasked pin latches a bit in a status vector. The interrupt output is the OR of that vector.

A separate clear-on-read block outside this one sends a one-cycle clear request with a bit vector. This block drops only those requested bits that are not masked. If a new event and a clear hit the same bit in the same cycle, the event wins, so no event is lost. After reset the filters take their starting level from the synchronized pins, and events stay suppressed until the pipeline is full, so a pin that is already high does not cause a false edge. The block has no streaming data path. Every pin is a plain level or a single-cycle strobe, and there is no back-pressure.

Top module: `pin_edge_irq`

## Requirements
- R1: While reset is held, and after reset is released with the pins held steady, the status vector is zero and the interrupt output is low, whatever the pin levels and edge selects are.
- R2: Each pin is sampled by two flops before filtering. With a debounce setting of 0, a pin change driven before clock edge 1 sets its status bit at edge 4 and not earlier.
- R3: With a debounce setting of N, the filtered level follows a pin only after the new level has been sampled for N+1 consecutive cycles. The status bit therefore sets at edge 4+N and is still clear after edge 3+N. A pulse that lasts only N cycles has no effect.
- R4: The edge-select bit of a pin set to 1 means a 0-to-1 transition is an event. Set to 0, it means a 1-to-0 transition is an event. The other direction never sets the status bit.
- R5: A pin whose mask bit is 1 never sets its status bit. An edge that arrives while the pin is masked is not kept and does not appear after the mask is removed.
- R6: The interrupt output is high exactly while at least one status bit is set.
- R7: A clear request drops a status bit only when that bit is 1 in the clear vector and 0 in the mask. The change shows after the clock edge that sampled the request. Other bits keep their value.
- R8: When a new event and a clear request hit the same bit in the same cycle, the bit stays set.
- R9: With a debounce setting of 0, a pin that toggles every two cycles has every selected edge captured. Pins are handled independently, so a rising-select pin and a falling-select pin driven by the same waveform each latch their own edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (about 32 kHz) clock for the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | NPINS | Raw asynchronous pin levels |
| dbn_len_i | input | DBW | Debounce length N in clock periods (extra stable samples required) |
| edge_rise_i | input | NPINS | Per-pin edge select: 1 rising, 0 falling |
| mask_i | input | NPINS | Per-pin mask: 1 blocks events and protects the bit from clearing |
| clr_i | input | 1 | One-cycle clear request strobe |
| clr_bits_i | input | NPINS | Bits to clear when clr_i is high |
| status_o | output | NPINS | Latched event status vector |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
A wrong internal state in this block shows at the ports as a status bit that rises one or more cycles away from edge 4+N, or that never rises, or that rises on the unselected direction. A debounce counter that is off by one moves the set edge by exactly one cycle. It also lets an N-cycle pulse through, which shows as a spurious status bit within N+6 cycles. A bad warm-up gate shows as a status bit set right after reset. A bad clear or priority path shows at the first edge after the clear request: a masked bit that disappears, or a bit set in the same cycle that is lost.

// File: rtl/pei_pkg.sv
package pei_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  // Cycles after reset release until synchronizer, filter and edge delay hold real pin data
  localparam int unsigned WARM_CYCLES = 4;

endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/pei_filter.sv
module pei_filter #(
  parameter int unsigned DBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           lvl_i,
  input  logic [DBW-1:0] limit_i,
  output logic           lvl_o
);

  logic           lvl_q;
  logic [DBW-1:0] cnt_q;

  // cnt_q counts the earlier mismatching samples; accept on the (limit+1)-th one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      lvl_q <= lvl_i;
      cnt_q <= '0;
    end else if (lvl_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == limit_i) begin
      lvl_q <= lvl_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  // R3: outside warm-up, a filtered change needs the full count of mismatching samples
  a_r3_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_i) && (lvl_q != $past(lvl_q))) |-> ($past(cnt_q) == $past(limit_i)));

  // R3: a change of the filtered level always moves toward the sampled input
  a_r3_follow_input: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(lvl_i)));

endmodule

// File: rtl/pei_evt.sv
module pei_evt
  import pei_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_sel_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);

  logic [W-1:0] lvl_d_q;
  logic [W-1:0] status_q;
  logic [W-1:0] edge_hit;
  logic [W-1:0] new_ev;
  logic [W-1:0] drop;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_d_q <= '0;
    else        lvl_d_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    always_comb begin
      if (edge_sel_e'(rise_sel_i[i]) == EDGE_RISE) edge_hit[i] = lvl_i[i] & ~lvl_d_q[i];
      else                                         edge_hit[i] = ~lvl_i[i] & lvl_d_q[i];
    end
  end

  assign new_ev = arm_i ? (edge_hit & ~mask_i) : '0;
  assign drop   = clr_i ? (clr_bits_i & ~mask_i) : '0;

  // set has priority over clear so that no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~drop) | new_ev;
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;

  // R1: nothing is latched before the pipeline is armed
  a_r1_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> ((status_q & ~$past(status_q)) == '0));

  // R5: a masked bit never goes from clear to set
  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> ((status_q & ~$past(status_q) & $past(mask_i)) == '0));

  // R7: a clear request never drops a masked bit
  a_r7_keep_masked: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (($past(status_q) & $past(mask_i) & ~status_q) == '0));

  // R8: an event in the same cycle as a clear survives
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (($past(new_ev) & ~status_q) == '0));

  // R6: without a clear request the interrupt cannot fall
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o);

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pei_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DBW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic [DBW-1:0]   dbn_len_i,
  input  logic [NPINS-1:0] edge_rise_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic             clr_i,
  input  logic [NPINS-1:0] clr_bits_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o
);

  localparam int unsigned WW = $clog2(WARM_CYCLES + 1);

  logic [WW-1:0]    warm_q;
  logic             armed;
  logic [NPINS-1:0] synced;
  logic [NPINS-1:0] filtered;

  // warm-up: filters copy the synchronized pins until real data has reached the edge delay
  always_ff @(posedge clk) begin
    if (!rst_n)                        warm_q <= '0;
    else if (warm_q != WW'(WARM_CYCLES)) warm_q <= warm_q + 1'b1;
  end

  assign armed = (warm_q == WW'(WARM_CYCLES));

  pei_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_i),
    .sync_o  (synced)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_flt
    pei_filter #(.DBW(DBW)) u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (!armed),
      .lvl_i   (synced[i]),
      .limit_i (dbn_len_i),
      .lvl_o   (filtered[i])
    );
  end

  pei_evt #(.W(NPINS)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (armed),
    .lvl_i      (filtered),
    .rise_sel_i (edge_rise_i),
    .mask_i     (mask_i),
    .clr_i      (clr_i),
    .clr_bits_i (clr_bits_i),
    .status_o   (status_o),
    .irq_o      (irq_o)
  );

  // R1: once armed, the block stays armed until the next reset
  a_r1_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R6: the interrupt is low whenever the status vector is empty
  a_r6_irq_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == '0) |-> !irq_o);

endmodule

// File: tb/sim_pin_edge_irq.sv
`timescale 1ns/1ps
module sim_pin_edge_irq;

  localparam int NP = 16;
  localparam int DB = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pins;
  logic [DB-1:0] dbn;
  logic [NP-1:0] rise;
  logic [NP-1:0] mask;
  logic          clr;
  logic [NP-1:0] clr_bits;
  logic [NP-1:0] status;
  logic          irq;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  pin_edge_irq #(.NPINS(NP), .DBW(DB)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .dbn_len_i   (dbn),
    .edge_rise_i (rise),
    .mask_i      (mask),
    .clr_i       (clr),
    .clr_bits_i  (clr_bits),
    .status_o    (status),
    .irq_o       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mask(input logic [NP-1:0] b);
    clr = 1'b1;
    clr_bits = b;
    step(1);
    clr = 1'b0;
    clr_bits = '0;
  endtask

  // one pin, one polarity, one debounce length
  task automatic sweep_one(input int b, input bit r, input int n);
    dbn = DB'(n);
    rise[b] = r;
    pins[b] = ~r;
    step(n + 8);
    clear_mask('1);
    check("R4 opposite direction ignored", 32'(status), 32'h0);
    pins[b] = r;
    step(3 + n);
    check("R3 status not set before edge 4+N", 32'(status), 32'h0);
    step(1);
    check("R2 R3 R4 status set at edge 4+N", 32'(status), 32'h1 << b);
    check("R6 irq with status set", 32'(irq), 32'h1);
    clear_mask('1);
    check("R7 unmasked bit cleared", 32'(status), 32'h0);
    check("R6 irq low when empty", 32'(irq), 32'h0);
    if (n > 0) begin
      pins[b] = ~r;
      step(n);
      pins[b] = r;
      step(n + 6);
      check("R3 N-cycle pulse rejected", 32'(status), 32'h0);
    end
  endtask

  initial begin
    int nv[5];
    nv = '{0, 1, 2, 3, 5};
    rst_n = 1'b0;
    pins = 16'hA5C3;
    dbn = '0;
    rise = 16'h0F0F;
    mask = '0;
    clr = 1'b0;
    clr_bits = '0;
    step(5);
    check("R1 status zero in reset", 32'(status), 32'h0);
    check("R1 irq low in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    step(10);
    check("R1 no event after reset", 32'(status), 32'h0);
    check("R1 irq low after reset", 32'(irq), 32'h0);

    pins = '0;
    rise = '1;
    step(10);
    clear_mask('1);

    for (int b = 0; b < NP; b++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 5; k++)
          sweep_one(b, p[0], nv[k]);

    // R5: masked edge is dropped and not remembered
    dbn = '0;
    pins = '0;
    rise = '1;
    step(10);
    clear_mask('1);
    mask[4] = 1'b1;
    pins[4] = 1'b1;
    step(8);
    check("R5 masked edge not latched", 32'(status), 32'h0);
    check("R5 irq stays low", 32'(irq), 32'h0);
    mask = '0;
    step(2);
    check("R5 unmask does not replay edge", 32'(status), 32'h0);

    // R7: clear respects clear vector and mask
    pins[5] = 1'b1;
    pins[6] = 1'b1;
    step(6);
    check("R7 two bits set", 32'(status), 32'h60);
    mask[6] = 1'b1;
    clear_mask(16'h0060);
    check("R7 masked bit kept", 32'(status), 32'h40);
    check("R6 irq from remaining bit", 32'(irq), 32'h1);
    mask = '0;
    clear_mask(16'h0020);
    check("R7 bit outside clear vector kept", 32'(status), 32'h40);
    clear_mask(16'h0040);
    check("R7 bit cleared once unmasked", 32'(status), 32'h0);
    check("R6 irq low after clear", 32'(irq), 32'h0);

    // R9 and R8: toggle every two cycles under a permanent clear request
    rise[0] = 1'b1;
    rise[1] = 1'b0;
    pins = '0;
    step(10);
    clear_mask('1);
    clr = 1'b1;
    clr_bits = '1;
    for (int c = 1; c <= 17; c++) begin
      if (c >= 2) begin
        int e;
        logic [31:0] exp;
        e = c - 1;
        exp = 32'h0;
        if (e == 4 || e == 8 || e == 12 || e == 16) exp = 32'h1;
        if (e == 6 || e == 10 || e == 14) exp = 32'h2;
        check("R9 R8 fast toggle capture", 32'(status), exp);
      end
      if ((c % 2 == 1) && (c <= 13)) pins[1:0] = ~pins[1:0];
      step(1);
    end
    clr = 1'b0;
    clr_bits = '0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule